// File: doc/BRIEF.md
# Video DRAM Strobe-Edge Cycle Decoder

This block sits at the front of a controller for a dual-port video DRAM. It watches the DRAM pins: the active-low row and column strobes, the transfer/output-enable pin, write enable and serial enable, plus the address and data buses. It samples them with a fast system clock. When the row strobe falls, the block works out which of six cycle kinds is starting. It also captures the row address and, for masked writes, a per-bit write mask taken from the data pins. For the rest of the cycle it follows the column strobe. It reports column addresses, per-access read and write pulses, an output-enable qualifier and, in transfer cycles, the serial start address.

Every pin passes through a two-stage synchronizer, so strobe edges are found on the synchronized samples. A decoded cycle and its latched row values stay put until the row strobe goes high again. At that point the cycle kind returns to idle.

Top module: `vram_cycle_decoder`

## Requirements
- R1: After reset, `cycle_type` is IDLE (0), `row_addr`, `col_addr` and `sam_start` are zero, `wmask` is all ones, and `col_stb`, `rd_stb`, `wr_stb`, `oe` and `xfer_stb` are low.
- R2: If `cas_n` is low when the row strobe falls, `cycle_type` becomes REFRESH (1), whatever the other pins are.
- R3: If `cas_n` is high and `dtoe_n` is low at the row strobe fall, the cycle is a transfer. `we_n` low with `se_n` low gives WR_XFER (2). `we_n` low with `se_n` high gives PSEUDO_XFER (3). `we_n` high gives RD_XFER (4) whatever `se_n` is.
- R4: If `cas_n` and `dtoe_n` are both high at the row strobe fall, `we_n` low gives MASK_RW (5) and `we_n` high gives NORMAL_RW (6).
- R5: In MASK_RW, `wmask` holds the data pins as they were at the row strobe fall, with bit i enabling writes on I/O i. In every other cycle kind `wmask` is all ones. Data pin changes after the fall have no effect on it.
- R6: `row_addr` takes the address at the row strobe fall and does not change for the rest of the cycle, even if the address pins change.
- R7: On each column strobe fall inside an active cycle, `col_addr` takes the address pins and `col_stb` pulses high for one clock. A column strobe fall while IDLE has no effect.
- R8: In MASK_RW or NORMAL_RW, each column strobe fall pulses `wr_stb` for one clock if `we_n` is low, or `rd_stb` if `we_n` is high. No such pulses occur in other cycle kinds.
- R9: `oe` is high only while a MASK_RW or NORMAL_RW cycle is active with both `cas_n` and `dtoe_n` low.
- R10: In the three transfer kinds, a column strobe fall pulses `xfer_stb` for one clock and loads `sam_start` with the column address.
- R11: When the row strobe rises, `cycle_type` returns to IDLE. `row_addr` and `wmask` keep their values.
- R12: A row strobe fall on the pins shows up on `cycle_type` after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe pin, active low |
| cas_n | input | 1 | Column strobe pin, active low |
| dtoe_n | input | 1 | Transfer select at row fall, output enable afterwards |
| we_n | input | 1 | Write enable / transfer direction |
| se_n | input | 1 | Serial enable |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq | input | DATA_W | Data pins, used as mask source |
| cycle_type | output | 3 | Decoded cycle kind (0 IDLE ... 6 NORMAL_RW) |
| row_addr | output | ADDR_W | Latched row address |
| col_addr | output | ADDR_W | Latest column address |
| wmask | output | DATA_W | Per-bit write enable mask |
| col_stb | output | 1 | One-clock pulse per column access |
| rd_stb | output | 1 | One-clock read access pulse |
| wr_stb | output | 1 | One-clock write access pulse |
| oe | output | 1 | Output drive qualifier |
| xfer_stb | output | 1 | One-clock transfer start pulse |
| sam_start | output | ADDR_W | Serial start address of a transfer |

## Verification
The decode is tried with a low column strobe under several settings of the other pins. This shows that refresh overrides everything else. All transfer combinations are applied, including read transfers with serial enable both high and low, which separates the don't-care pin from the ones that matter. Mask and normal read/write cycles use non-trivial data patterns, and the data and address pins are changed after the row edge. This distinguishes a value latched at the edge from one that follows the pins. Column accesses with write enable low and high, accesses in transfer cycles, and a column strobe while idle separate the read, write and transfer pulses from each other.

// File: rtl/vram_cycle_decoder.sv
module vram_cycle_decoder #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              dtoe_n,
  input  logic              we_n,
  input  logic              se_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq,
  output logic [2:0]        cycle_type,
  output logic [ADDR_W-1:0] row_addr,
  output logic [ADDR_W-1:0] col_addr,
  output logic [DATA_W-1:0] wmask,
  output logic              col_stb,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              oe,
  output logic              xfer_stb,
  output logic [ADDR_W-1:0] sam_start
);
  localparam logic [2:0] CT_IDLE = 3'd0;
  localparam logic [2:0] CT_REF  = 3'd1;
  localparam logic [2:0] CT_WRX  = 3'd2;
  localparam logic [2:0] CT_PSX  = 3'd3;
  localparam logic [2:0] CT_RDX  = 3'd4;
  localparam logic [2:0] CT_MRW  = 3'd5;
  localparam logic [2:0] CT_NRW  = 3'd6;

  localparam int PW = 5 + ADDR_W + DATA_W;
  localparam logic [PW-1:0] PIN_RST = {5'b11111, {(ADDR_W + DATA_W){1'b0}}};

  logic [PW-1:0] s1, s2;
  logic ras_q, cas_q;
  logic s_ras, s_cas, s_dt, s_we, s_se;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_dq;
  logic [2:0] dec;

  assign {s_ras, s_cas, s_dt, s_we, s_se} = s2[PW-1 -: 5];
  assign s_addr = s2[DATA_W +: ADDR_W];
  assign s_dq   = s2[DATA_W-1:0];

  wire active   = cycle_type != CT_IDLE;
  wire rw_cyc   = (cycle_type == CT_MRW) || (cycle_type == CT_NRW);
  wire xfer_cyc = (cycle_type == CT_WRX) || (cycle_type == CT_PSX) || (cycle_type == CT_RDX);
  wire ras_fall = ras_q & ~s_ras;
  wire ras_rise = ~ras_q & s_ras;
  wire cas_fall = cas_q & ~s_cas & ~s_ras & active;

  always_comb begin
    if (!s_cas)     dec = CT_REF;
    else if (!s_dt) dec = s_we ? CT_RDX : (s_se ? CT_PSX : CT_WRX);
    else            dec = s_we ? CT_NRW : CT_MRW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= PIN_RST;
      s2    <= PIN_RST;
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      s1    <= {ras_n, cas_n, dtoe_n, we_n, se_n, addr, dq};
      s2    <= s1;
      ras_q <= s_ras;
      cas_q <= s_cas;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycle_type <= CT_IDLE;
      row_addr   <= '0;
      wmask      <= '1;
    end else if (ras_fall) begin
      cycle_type <= dec;
      row_addr   <= s_addr;
      wmask      <= (dec == CT_MRW) ? s_dq : '1;
    end else if (ras_rise) begin
      cycle_type <= CT_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_addr  <= '0;
      sam_start <= '0;
      col_stb   <= 1'b0;
      rd_stb    <= 1'b0;
      wr_stb    <= 1'b0;
      xfer_stb  <= 1'b0;
      oe        <= 1'b0;
    end else begin
      col_stb  <= cas_fall;
      rd_stb   <= cas_fall & rw_cyc & s_we;
      wr_stb   <= cas_fall & rw_cyc & ~s_we;
      xfer_stb <= cas_fall & xfer_cyc;
      oe       <= rw_cyc & ~s_ras & ~s_cas & ~s_dt;
      if (cas_fall) col_addr <= s_addr;
      if (cas_fall && xfer_cyc) sam_start <= s_addr;
    end
  end
endmodule

// File: rtl/vram_cycle_decoder_chk.sv
module vram_cycle_decoder_chk #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cycle_type,
  input logic [ADDR_W-1:0] row_addr,
  input logic [DATA_W-1:0] wmask,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic              xfer_stb,
  input logic              oe
);
  wire rw = (cycle_type == 3'd5) || (cycle_type == 3'd6);
  wire xf = (cycle_type == 3'd2) || (cycle_type == 3'd3) || (cycle_type == 3'd4);

  p_normal_mask_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_type == 3'd6) |-> (wmask == {DATA_W{1'b1}}));
  p_row_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_type != 3'd0 && $past(cycle_type) != 3'd0) |-> $stable(row_addr));
  p_access_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> (rw && $onehot0({rd_stb, wr_stb})));
  p_oe_rw_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> rw);
  p_xfer_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb |-> (xf && !rd_stb && !wr_stb));
  p_kind_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_type != 3'd0 && $past(cycle_type) != 3'd0) |-> (cycle_type == $past(cycle_type)));
endmodule

bind vram_cycle_decoder vram_cycle_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cycle_type(cycle_type), .row_addr(row_addr),
  .wmask(wmask), .rd_stb(rd_stb), .wr_stb(wr_stb), .xfer_stb(xfer_stb), .oe(oe)
);

// File: tb/test_vram_cycle_decoder.sv
`timescale 1ns/1ps
module test_vram_cycle_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, dtoe_n = 1'b1, we_n = 1'b1, se_n = 1'b1;
  logic [8:0] addr = '0;
  logic [3:0] dq = '0;
  logic [2:0] cycle_type;
  logic [8:0] row_addr, col_addr, sam_start;
  logic [3:0] wmask;
  logic col_stb, rd_stb, wr_stb, oe, xfer_stb;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  vram_cycle_decoder i_vram_cycle_decoder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .dtoe_n(dtoe_n),
    .we_n(we_n), .se_n(se_n), .addr(addr), .dq(dq), .cycle_type(cycle_type),
    .row_addr(row_addr), .col_addr(col_addr), .wmask(wmask), .col_stb(col_stb),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .oe(oe), .xfer_stb(xfer_stb), .sam_start(sam_start)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start_cycle(input logic c, input logic d, input logic w, input logic s,
                             input logic [8:0] a, input logic [3:0] m);
    cas_n = c; dtoe_n = d; we_n = w; se_n = s; addr = a; dq = m;
    step(3);
    ras_n = 1'b0;
    step(3);
  endtask

  task automatic end_cycle();
    ras_n = 1'b1; cas_n = 1'b1; dtoe_n = 1'b1; we_n = 1'b1; se_n = 1'b1;
    step(3);
  endtask

  task automatic column(input string req, input logic [8:0] a, input logic w, input logic d,
                        input logic e_rd, input logic e_wr, input logic e_x, input logic e_oe);
    addr = a; we_n = w; dtoe_n = d; cas_n = 1'b0;
    step(3);
    chk({req, " col_stb"}, col_stb, 1);
    chk({req, " col_addr"}, col_addr, a);
    chk({req, " rd_stb"}, rd_stb, e_rd);
    chk({req, " wr_stb"}, wr_stb, e_wr);
    chk({req, " xfer_stb"}, xfer_stb, e_x);
    chk({req, " oe"}, oe, e_oe);
    step(1);
    chk({req, " pulse width"}, col_stb | rd_stb | wr_stb | xfer_stb, 0);
    cas_n = 1'b1;
    step(3);
  endtask

  task automatic t_reset();
    chk("R1 type", cycle_type, 0);
    chk("R1 mask", wmask, 4'hF);
    chk("R1 addrs", row_addr | col_addr | sam_start, 0);
    chk("R1 strobes", {col_stb, rd_stb, wr_stb, oe, xfer_stb}, 0);
  endtask

  task automatic t_refresh();
    start_cycle(1'b0, 1'b0, 1'b0, 1'b0, 9'h011, 4'h3);
    chk("R2 refresh dt/we/se low", cycle_type, 1);
    chk("R5 refresh mask", wmask, 4'hF);
    end_cycle();
    start_cycle(1'b0, 1'b1, 1'b1, 1'b1, 9'h022, 4'h0);
    chk("R2 refresh others high", cycle_type, 1);
    end_cycle();
  endtask

  task automatic t_latency();
    cas_n = 1'b1; dtoe_n = 1'b1; we_n = 1'b1; addr = 9'h0AA;
    step(3);
    ras_n = 1'b0;
    step(2);
    chk("R12 not after 2 edges", cycle_type, 0);
    step(1);
    chk("R12 after 3 edges", cycle_type, 6);
    end_cycle();
  endtask

  task automatic t_transfers();
    start_cycle(1'b1, 1'b0, 1'b0, 1'b0, 9'h100, 4'h0);
    chk("R3 write transfer", cycle_type, 2);
    column("R10 wrx", 9'h1F0, 1'b1, 1'b1, 0, 0, 1, 0);
    chk("R10 sam_start", sam_start, 9'h1F0);
    end_cycle();
    start_cycle(1'b1, 1'b0, 1'b0, 1'b1, 9'h101, 4'h0);
    chk("R3 pseudo transfer", cycle_type, 3);
    end_cycle();
    start_cycle(1'b1, 1'b0, 1'b1, 1'b0, 9'h102, 4'h0);
    chk("R3 read transfer se low", cycle_type, 4);
    column("R10 rdx", 9'h033, 1'b0, 1'b0, 0, 0, 1, 0);
    chk("R10 sam_start rdx", sam_start, 9'h033);
    end_cycle();
    start_cycle(1'b1, 1'b0, 1'b1, 1'b1, 9'h103, 4'h0);
    chk("R3 read transfer se high", cycle_type, 4);
    end_cycle();
  endtask

  task automatic t_mask_rw();
    start_cycle(1'b1, 1'b1, 1'b0, 1'b1, 9'h155, 4'hA);
    chk("R4 mask rw", cycle_type, 5);
    chk("R5 mask latched", wmask, 4'hA);
    chk("R6 row latched", row_addr, 9'h155);
    dq = 4'h5;
    column("R8 mask write", 9'h0C3, 1'b0, 1'b1, 0, 1, 0, 0);
    column("R8 mask read oe", 9'h0C4, 1'b1, 1'b0, 1, 0, 0, 1);
    chk("R5 mask unaffected", wmask, 4'hA);
    chk("R6 row held", row_addr, 9'h155);
    end_cycle();
    chk("R11 idle", cycle_type, 0);
    chk("R11 row kept", row_addr, 9'h155);
    chk("R11 mask kept", wmask, 4'hA);
    chk("R9 oe off idle", oe, 0);
  endtask

  task automatic t_normal_rw();
    start_cycle(1'b1, 1'b1, 1'b1, 1'b0, 9'h0F0, 4'h0);
    chk("R4 normal rw", cycle_type, 6);
    chk("R5 normal mask ones", wmask, 4'hF);
    column("R8 normal read", 9'h00F, 1'b1, 1'b1, 1, 0, 0, 0);
    column("R8 normal write", 9'h1E1, 1'b0, 1'b1, 0, 1, 0, 0);
    chk("R6 row held normal", row_addr, 9'h0F0);
    chk("R10 sam untouched", sam_start, 9'h033);
    end_cycle();
  endtask

  task automatic t_idle_cas();
    addr = 9'h1AB; cas_n = 1'b0;
    step(3);
    chk("R7 idle col_stb", col_stb, 0);
    step(1);
    chk("R7 idle col_addr", col_addr, 9'h1E1);
    cas_n = 1'b1;
    step(3);
  endtask

  initial begin
    step(2);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_refresh();
    t_latency();
    t_transfers();
    t_mask_rw();
    t_normal_rw();
    t_idle_cas();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule